// File: doc/BRIEF.md
# Inbound Memory Window Decoder

This block sits on the inbound side of a bus bridge. It decides whether an incoming bus-side address falls inside one of three programmable memory windows and, if it does, what the host-side address is. Each window is described by a single 16-bit setting. That setting packs a 1 MB aligned bus-side base and a 4-bit logarithmic size code. The code covers sizes from 1 MB (code 0) up to 2 GB (code 11), and each step doubles the size.

Every window maps onto host address zero. The translated address is therefore the offset of the incoming address inside the window that hit. When windows overlap, the lowest-numbered window wins. A lookup is presented with a valid strobe, and its result appears one clock later on registered outputs. Window settings are written and read back through a small port addressed by byte offset.

Top module: `ibw_decoder`

## Requirements
- R1: After reset, every window holds base 0 with size code 0xF, so no lookup hits and each window setting reads back as 0x000F.
- R2: A write to byte offset 0x50, 0x54 or 0x58 loads window 1, 2 or 3 respectively. The setting word carries the base (address bits 31:20) in bits 15:4 and the size code in bits 3:0. A write to any other offset changes no window. Reading a window offset returns its setting, and reading any other offset returns 0.
- R3: A size code c from 0 to 11 gives a window of 2^(20+c) bytes.
- R4: A window whose size code is 12 to 15 never hits.
- R5: An address hits a window when its bits at and above position 20+c equal the same bits of the window base. Base bits below that position have no effect.
- R6: When more than one window hits, window 1 beats windows 2 and 3, and window 2 beats window 3. res_win reports 0, 1 or 2 for windows 1, 2 or 3.
- R7: On a hit, res_addr equals the lookup address ANDed with (window size − 1).
- R8: On a miss, and in any cycle without a lookup, res_hit is 0 and res_win and res_addr are 0.
- R9: res_valid and the result fields appear exactly one clock after the lookup is presented on lk_valid/lk_addr.
- R10: A lookup presented in the same cycle as a window write is decoded with the settings from before that write. Lookups presented in later cycles see the new setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Window setting write strobe |
| cfg_off | input | 8 | Byte offset of the write |
| cfg_wdata | input | 16 | Setting word: base in bits 15:4, size code in bits 3:0 |
| cfg_rd_off | input | 8 | Byte offset for readback |
| cfg_rdata | output | 16 | Setting at cfg_rd_off, or 0 |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | 32 | Bus-side address to decode |
| res_valid | output | 1 | Result valid, one clock after lk_valid |
| res_hit | output | 1 | Some window matched |
| res_win | output | 2 | Index of the winning window |
| res_addr | output | 32 | Translated host address, or 0 on miss |

## Verification
The bench builds the block with its default parameters: three windows, 32-bit addresses and a 1 MB minimum granule. With these values the top size code, 11, covers half of the whole address space. This lets the bench place a 2 GB window over both smaller windows to exercise priority, and use the wrap past the top of the address space as a boundary case. Because the code field is 4 bits wide, the four invalid codes can be reached directly. Each size code is swept from 1 MB to 2 GB at the last byte inside the window and the first byte past it.

// File: rtl/ibw_pkg.sv
package ibw_pkg;
  localparam int ADDR_W   = 32;
  localparam int BASE_LSB = 20;
  localparam int CODE_W   = 4;
  localparam int CFG_W    = ADDR_W - BASE_LSB + CODE_W;
  localparam int MAX_CODE = ADDR_W - 1 - BASE_LSB;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef struct packed {
    logic [ADDR_W-BASE_LSB-1:0] base;
    logic [CODE_W-1:0]          code;
  } win_cfg_t;

  // true when the size code names a window that fits the address space
  function automatic logic code_ok(input logic [CODE_W-1:0] c);
    return int'(c) <= MAX_CODE;
  endfunction

  // ones over the offset bits of a window with size code c
  function automatic addr_t offset_mask(input logic [CODE_W-1:0] c);
    addr_t m;
    for (int i = 0; i < ADDR_W; i++) m[i] = (i < BASE_LSB + int'(c));
    return m;
  endfunction

  function automatic addr_t base_addr(input win_cfg_t w);
    return {w.base, {BASE_LSB{1'b0}}};
  endfunction
endpackage

// File: rtl/ibw_regfile.sv
module ibw_regfile
  import ibw_pkg::*;
#(
  parameter int NUM_WIN   = 3,
  parameter int OFF_W     = 8,
  parameter int FIRST_OFF = 'h50,
  parameter int STRIDE    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [OFF_W-1:0]            wr_off,
  input  logic [CFG_W-1:0]            wr_data,
  input  logic [OFF_W-1:0]            rd_off,
  output logic [CFG_W-1:0]            rd_data,
  output win_cfg_t [NUM_WIN-1:0]      cfg_q
);
  localparam win_cfg_t RST_CFG = '{base: '0, code: '1};

  logic [NUM_WIN-1:0] wr_sel;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    localparam logic [OFF_W-1:0] MY_OFF = (OFF_W)'(FIRST_OFF + i * STRIDE);

    assign wr_sel[i] = wr_en && (wr_off == MY_OFF);

    always_ff @(posedge clk) begin
      if (!rst_n)         cfg_q[i] <= RST_CFG;
      else if (wr_sel[i]) cfg_q[i] <= win_cfg_t'(wr_data);
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel[i] |=> (cfg_q[i] == win_cfg_t'($past(wr_data)))); // R2
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_WIN; i++)
      if (rd_off == (OFF_W)'(FIRST_OFF + i * STRIDE)) rd_data = cfg_q[i];
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel)); // R2
  AST_STRAY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel == '0) |=> $stable(cfg_q)); // R2
endmodule

// File: rtl/ibw_match.sv
module ibw_match
  import ibw_pkg::*;
#(
  parameter int NUM_WIN = 3
) (
  input  addr_t                   addr,
  input  win_cfg_t [NUM_WIN-1:0]  cfg,
  output logic [NUM_WIN-1:0]      hit_vec,
  output addr_t [NUM_WIN-1:0]     offs
);
  for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
    addr_t mask;
    assign mask       = offset_mask(cfg[i].code);
    assign hit_vec[i] = code_ok(cfg[i].code) &&
                        ((addr & ~mask) == (base_addr(cfg[i]) & ~mask));
    assign offs[i]    = addr & mask;
  end
endmodule

// File: rtl/ibw_select.sv
module ibw_select
  import ibw_pkg::*;
#(
  parameter int NUM_WIN = 3,
  parameter int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic [NUM_WIN-1:0]   hit_vec,
  input  addr_t [NUM_WIN-1:0]  offs,
  output logic                 any_hit,
  output logic [IDX_W-1:0]     win_idx,
  output addr_t                win_addr
);
  logic [NUM_WIN-1:0] grant;

  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (hit_vec[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  always_comb begin
    win_idx  = '0;
    win_addr = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (grant[i]) begin
        win_idx  = (IDX_W)'(i);
        win_addr = offs[i];
      end
    end
  end

  assign any_hit = |grant;
endmodule

// File: rtl/ibw_decoder.sv
module ibw_decoder
  import ibw_pkg::*;
#(
  parameter int NUM_WIN   = 3,
  parameter int OFF_W     = 8,
  parameter int FIRST_OFF = 'h50,
  parameter int STRIDE    = 4,
  parameter int IDX_W     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [OFF_W-1:0]  cfg_off,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic [OFF_W-1:0]  cfg_rd_off,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              res_valid,
  output logic              res_hit,
  output logic [IDX_W-1:0]  res_win,
  output logic [ADDR_W-1:0] res_addr
);
  win_cfg_t [NUM_WIN-1:0] cfg_q;
  logic [NUM_WIN-1:0]     hit_vec;
  addr_t [NUM_WIN-1:0]    offs;
  logic                   sel_hit;
  logic [IDX_W-1:0]       sel_idx;
  addr_t                  sel_addr;

  ibw_regfile #(.NUM_WIN(NUM_WIN), .OFF_W(OFF_W), .FIRST_OFF(FIRST_OFF),
                .STRIDE(STRIDE)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_off(cfg_off),
    .wr_data(cfg_wdata), .rd_off(cfg_rd_off), .rd_data(cfg_rdata),
    .cfg_q(cfg_q));

  ibw_match #(.NUM_WIN(NUM_WIN)) match_i (
    .addr(lk_addr), .cfg(cfg_q), .hit_vec(hit_vec), .offs(offs));

  ibw_select #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) sel_i (
    .hit_vec(hit_vec), .offs(offs), .any_hit(sel_hit),
    .win_idx(sel_idx), .win_addr(sel_addr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_win   <= '0;
      res_addr  <= '0;
    end else begin
      res_valid <= lk_valid;
      res_hit   <= lk_valid && sel_hit;
      res_win   <= (lk_valid && sel_hit) ? sel_idx : '0;
      res_addr  <= (lk_valid && sel_hit) ? sel_addr : '0;
    end
  end

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!res_valid && !res_hit)); // R8
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !res_hit |-> (res_addr == '0 && res_win == '0)); // R8

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_chk
    localparam logic [NUM_WIN-1:0] LOWER = (NUM_WIN)'((1 << i) - 1);
    AST_WIN_CODE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (res_hit && res_win == (IDX_W)'(i)) |-> $past(code_ok(cfg_q[i].code))); // R4
    AST_WIN_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
      (res_hit && res_win == (IDX_W)'(i)) |->
        ($past(hit_vec[i]) && (($past(hit_vec) & LOWER) == '0))); // R6
    AST_OFFSET_FITS: assert property (@(posedge clk) disable iff (!rst_n)
      (res_hit && res_win == (IDX_W)'(i)) |->
        ((res_addr & ~$past(offset_mask(cfg_q[i].code))) == '0)); // R7
  end
endmodule

// File: tb/ibw_decoder_tb.sv
module ibw_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_off = '0;
  logic [15:0] cfg_wdata = '0;
  logic [7:0]  cfg_rd_off = 8'h50;
  logic [15:0] cfg_rdata;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        res_valid, res_hit;
  logic [1:0]  res_win;
  logic [31:0] res_addr;

  always #10 clk = ~clk;

  ibw_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_off(cfg_off),
    .cfg_wdata(cfg_wdata), .cfg_rd_off(cfg_rd_off), .cfg_rdata(cfg_rdata),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .res_valid(res_valid),
    .res_hit(res_hit), .res_win(res_win), .res_addr(res_addr));

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference state: settings of the three windows
  int unsigned mdl [3];
  // pending expectations for the next sample point
  longint e_v, e_hit, e_win, e_addr;
  int     p_rd;
  string  p_tag;

  task automatic chk(input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic longint mdl_read(input int off);
    for (int k = 0; k < 3; k++)
      if (off == 'h50 + 4 * k) return longint'(mdl[k]);
    return 0;
  endfunction

  task automatic predict(input bit v, input int unsigned a);
    e_v = v; e_hit = 0; e_win = 0; e_addr = 0;
    if (!v) return;
    for (int w = 0; w < 3; w++) begin
      longint size, base;
      int code;
      code = int'(mdl[w] % 16);
      if (code > 11) continue;
      size = longint'(1) << (20 + code);
      base = longint'(mdl[w] / 16) * (longint'(1) << 20);
      if ((longint'(a) / size) == (base / size)) begin
        e_hit = 1; e_win = w; e_addr = longint'(a) % size;
        return;
      end
    end
  endtask

  task automatic step(input bit wr, input int off, input int wd, input int rdo,
                      input bit v, input int unsigned a, input string tag);
    @(negedge clk);
    chk(p_tag, "res_valid", res_valid, e_v);
    chk(p_tag, "res_hit", res_hit, e_hit);
    chk(p_tag, "res_win", res_win, e_win);
    chk(p_tag, "res_addr", res_addr, e_addr);
    chk(p_tag, "cfg_rdata", cfg_rdata, mdl_read(p_rd));
    cfg_wr_en = wr; cfg_off = off[7:0]; cfg_wdata = wd[15:0];
    cfg_rd_off = rdo[7:0]; lk_valid = v; lk_addr = a;
    predict(v, a);            // decoded against pre-write settings (R10)
    for (int k = 0; k < 3; k++)
      if (wr && off == 'h50 + 4 * k) mdl[k] = wd & 'hFFFF;
    p_rd = rdo; p_tag = tag;
  endtask

  task automatic look(input int unsigned a, input string tag);
    step(0, 0, 0, 'h50, 1, a, tag);
  endtask

  task automatic setw(input int idx, input int base12, input int code,
                      input string tag);
    step(1, 'h50 + 4 * idx, (base12 << 4) | code, 'h50 + 4 * idx, 0, 0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 3; k++) mdl[k] = 'h000F;
    e_v = 0; e_hit = 0; e_win = 0; e_addr = 0; p_rd = 'h50; p_tag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state, readback of every window, lookups miss
    step(0, 0, 0, 'h54, 1, 32'h0000_0000, "R1");
    step(0, 0, 0, 'h58, 1, 32'h1234_5678, "R1");
    look(32'hFFFF_FFFF, "R1");
    // R2: programming and stray offsets
    setw(0, 'h100, 0, "R2");
    step(1, 'h5C, 'h4003, 'h5C, 0, 0, "R2");
    step(1, 'h4C, 'h0000, 'h4C, 0, 0, "R2");
    step(0, 0, 0, 'h54, 1, 32'h4000_0000, "R2");
    // R3 / R7: 1 MB window
    look(32'h100A_BCDE, "R7");
    look(32'h1010_0000, "R3");
    look(32'h0FFF_FFFF, "R3");
    // R5: base bits below the size are ignored (16 MB with base 0x405)
    setw(1, 'h405, 4, "R5");
    look(32'h40FF_FFFF, "R5");
    look(32'h4000_0000, "R5");
    look(32'h4100_0000, "R5");
    // 2 GB window at top
    setw(2, 'h800, 11, "R3");
    look(32'hFFFF_FFFF, "R3");
    look(32'h8000_0000, "R7");
    look(32'h7FFF_FFFF, "R8");
    // R6: overlap priority
    setw(2, 'h000, 11, "R6");
    look(32'h100A_BCDE, "R6");
    look(32'h4012_3456, "R6");
    look(32'h2000_0000, "R6");
    // R4: invalid codes
    for (int c = 12; c < 16; c++) begin
      setw(0, 'h100, c, "R4");
      look(32'h100A_BCDE, "R4");
    end
    setw(2, 'h000, 12, "R4");
    look(32'h2000_0000, "R4");
    // R3: sweep of every size code on window 2
    for (int c = 0; c < 12; c++) begin
      int unsigned sz;
      sz = 32'd1 << (20 + c);
      setw(1, 'hC00, c, "R3");
      look(32'hC000_0000 + sz - 1, "R3");
      look(32'hC000_0000 + sz, "R3");
    end
    // R10: write and lookup in the same cycle
    setw(0, 'h200, 15, "R10");
    step(1, 'h50, ('h200 << 4) | 1, 'h50, 1, 32'h2010_0000, "R10");
    look(32'h2010_0000, "R10");
    // R9 / R8: idle cycles
    step(0, 0, 0, 'h50, 0, 32'h2010_0000, "R9");
    look(32'h2000_0004, "R9");
    step(0, 0, 0, 'h54, 0, 32'h0, "R8");
    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      int unsigned r, a;
      int w;
      r = $urandom;
      w = int'(r % 3);
      if (r[7:6] == 2'b00)
        setw(w, int'($urandom % 4096), int'($urandom % 16), "R5");
      else begin
        a = ((mdl[w] >> 4) << 20) ^ ($urandom & ((32'd1 << (20 + ($urandom % 12))) - 1));
        step(0, 0, 0, 'h50 + 4 * int'($urandom % 4), r[5] | r[4], a, "R6");
      end
    end
    step(0, 0, 0, 'h50, 0, 0, "R8");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule